// File: doc/BRIEF.md
# Prescaled Multi-channel Down-counting Timer Unit

This block holds a small bank of down-counting timers that all advance on a common time base. A single reloadable prescaler counts down on every clock; each time it passes through zero it reloads itself and emits a one-cycle tick. Every timer that is running steps down by one on each tick. When a timer meets a tick while already at zero, an underflow occurs. The timer then either restarts from its own reload value or parks at zero, and it can raise a one-cycle interrupt pulse.

Software reaches the block through a plain word-addressed register port with a write strobe and a combinational read path. A four-word common group at the bottom of the map holds the prescaler. Each timer follows in its own four-word group. The number of timers is a parameter from 1 to 8.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset every count, reload and control register reads as 0, no interrupt output is high, and the status word (common word 2) reads the number of timers.
- R2: Word addresses are laid out as follows. Word 0 is the prescaler count, word 1 the prescaler reload, word 2 the status word and word 3 is spare. Timer n sits at words 4+4n (count), 5+4n (reload), 6+4n (control) and 7+4n (spare). Spare words and the groups of timers that are not built read 0 and ignore writes. Counts and reloads keep only their low CNT_W bits.
- R3: The prescaler decrements on every clock. In the cycle it holds 0 it produces a tick and reloads from the prescaler reload register, so ticks come every reload+1 clocks.
- R4: Control bit 0 (run) enables counting: a running timer decrements by one per tick. A timer with run clear holds its count.
- R5: With control bit 1 (auto-reload) set, a tick that finds the count at 0 reloads it from the timer's reload register and counting continues, giving an underflow every reload+1 ticks.
- R6: With control bit 1 clear, a tick that finds the count at 0 clears the run bit, and the count stays at 0.
- R7: Writing control bit 2 as 1 copies the reload register into the count. Writing it as 0 leaves the count untouched. Bit 2 always reads back as 0.
- R8: If control bit 3 (interrupt enable) is set, an underflow drives that timer's interrupt output high for the clock cycle after the underflow tick. If bit 3 is clear, the output stays low.
- R9: A register write to a timer takes priority over that timer's count step in the same cycle, so a written count is read back unchanged in the next cycle.
- R10: Timers count, underflow and interrupt independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq | output | NUM_TIMERS | One interrupt pulse line per timer |

## Verification
The hardest cases to reach from the ports are those where a tick and another event land on the same clock. One is a tick arriving on the cycle a register write hits the same timer. The other is a tick that finds a timer at zero while the prescaler is running slower than the clock. The bench forces the first case by leaving the prescaler reload at 0, so every clock is a tick, then writes a count into a running timer and reads it back on the next cycle. For the slow-prescaler case it sets a prescaler reload of 3 and counts interrupt pulses over a window that is a whole multiple of the expected period. The pulse count then comes out exact whatever the phase between the prescaler and the timer.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

    // Position of a register inside a four-word group
    typedef enum logic [1:0] {
        SLOT_COUNT  = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_CTRL   = 2'd2,
        SLOT_SPARE  = 2'd3
    } slot_e;

    // Control word bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_LOAD = 2;
    localparam int CTL_IRQ  = 3;

    typedef struct packed {
        logic irq_en;
        logic auto_rl;
        logic run;
    } chan_cfg_t;

endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_count,
    input  logic             wr_reload,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] count_o,
    output logic [PRE_W-1:0] reload_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] count;
        logic [PRE_W-1:0] reload;
    } pre_state_t;

    pre_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        tick_o  = (state_q.count == '0);
        if (tick_o) begin
            state_d.count = state_q.reload;
        end else begin
            state_d.count = state_q.count - 1'b1;
        end
        if (wr_reload) begin
            state_d.reload = wdata;
        end
        if (wr_count) begin
            state_d.count = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o  = state_q.count;
    assign reload_o = state_q.reload;

endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
    import mtu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  slot_e            wr_slot,
    input  logic [CNT_W-1:0] wr_value,
    input  logic [3:0]       wr_ctrl,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output chan_cfg_t        cfg_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        chan_cfg_t        cfg;
        logic             irq;
    } chan_state_t;

    chan_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = 1'b0;
        if (wr_en) begin
            // a write owns the channel for this cycle
            unique case (wr_slot)
                SLOT_COUNT:  state_d.count  = wr_value;
                SLOT_RELOAD: state_d.reload = wr_value;
                SLOT_CTRL: begin
                    state_d.cfg.run     = wr_ctrl[CTL_RUN];
                    state_d.cfg.auto_rl = wr_ctrl[CTL_AUTO];
                    state_d.cfg.irq_en  = wr_ctrl[CTL_IRQ];
                    if (wr_ctrl[CTL_LOAD]) begin
                        state_d.count = state_q.reload;
                    end
                end
                default: ;
            endcase
        end else if (tick && state_q.cfg.run) begin
            if (state_q.count == '0) begin
                state_d.irq = state_q.cfg.irq_en;
                if (state_q.cfg.auto_rl) begin
                    state_d.count = state_q.reload;
                end else begin
                    state_d.cfg.run = 1'b0;
                end
            end else begin
                state_d.count = state_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o  = state_q.count;
    assign reload_o = state_q.reload;
    assign cfg_o    = state_q.cfg;
    assign irq_o    = state_q.irq;

endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
    import mtu_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] grp;
    slot_e            slot;

    logic             tick;
    logic [PRE_W-1:0] pre_val;
    logic [PRE_W-1:0] pre_rld;
    logic             pre_wr_val;
    logic             pre_wr_rld;

    logic [NUM_TIMERS-1:0]            ch_hit;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_arr;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] rld_arr;
    logic [NUM_TIMERS-1:0]            run_vec;
    logic [NUM_TIMERS-1:0]            auto_vec;
    logic [NUM_TIMERS-1:0]            ie_vec;

    wire unused_wdata_bits = ^reg_wdata;

    assign grp  = reg_addr[ADDR_W-1:2];
    assign slot = slot_e'(reg_addr[1:0]);

    assign pre_wr_val = reg_wr && (grp == '0) && (slot == SLOT_COUNT);
    assign pre_wr_rld = reg_wr && (grp == '0) && (slot == SLOT_RELOAD);

    mtu_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_count  (pre_wr_val),
        .wr_reload (pre_wr_rld),
        .wdata     (reg_wdata[PRE_W-1:0]),
        .count_o   (pre_val),
        .reload_o  (pre_rld),
        .tick_o    (tick)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        chan_cfg_t cfg_w;

        assign ch_hit[g] = reg_wr && (grp == GRP_W'(g + 1));

        mtu_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_en    (ch_hit[g]),
            .wr_slot  (slot),
            .wr_value (reg_wdata[CNT_W-1:0]),
            .wr_ctrl  (reg_wdata[3:0]),
            .count_o  (cnt_arr[g]),
            .reload_o (rld_arr[g]),
            .cfg_o    (cfg_w),
            .irq_o    (irq[g])
        );

        assign run_vec[g]  = cfg_w.run;
        assign auto_vec[g] = cfg_w.auto_rl;
        assign ie_vec[g]   = cfg_w.irq_en;
    end

    always_comb begin
        reg_rdata = '0;
        if (grp == '0) begin
            unique case (slot)
                SLOT_COUNT:  reg_rdata = DATA_W'(pre_val);
                SLOT_RELOAD: reg_rdata = DATA_W'(pre_rld);
                SLOT_CTRL:   reg_rdata = DATA_W'(NUM_TIMERS);
                default:     reg_rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (grp == GRP_W'(i + 1)) begin
                    unique case (slot)
                        SLOT_COUNT:  reg_rdata = DATA_W'(cnt_arr[i]);
                        SLOT_RELOAD: reg_rdata = DATA_W'(rld_arr[i]);
                        SLOT_CTRL:   reg_rdata = DATA_W'({ie_vec[i], 1'b0, auto_vec[i], run_vec[i]});
                        default:     reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
    parameter int NUM_TIMERS = 4,
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tick,
    input logic                            pre_wr_val,
    input logic [PRE_W-1:0]                pre_val,
    input logic [PRE_W-1:0]                pre_rld,
    input logic [NUM_TIMERS-1:0]           ch_hit,
    input logic [NUM_TIMERS-1:0]           run_vec,
    input logic [NUM_TIMERS-1:0]           auto_vec,
    input logic [NUM_TIMERS-1:0]           ie_vec,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_TIMERS-1:0]           irq,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [DATA_W-1:0]               reg_rdata
);

    assert_tick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pre_wr_val) |=> (pre_val == $past(pre_rld)));

    assert_load_bit_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr[1:0] == 2'd2) && (reg_addr[ADDR_W-1:2] != '0)) |-> (reg_rdata[2] == 1'b0));

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[g] && !ch_hit[g]) |=> (cnt_arr[g] == $past(cnt_arr[g])));

        assert_stop_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && run_vec[g] && !auto_vec[g] && (cnt_arr[g] == '0) && !ch_hit[g])
            |=> (!run_vec[g] && (cnt_arr[g] == '0)));

        assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> ($past(tick) && $past(ie_vec[g]) && $past(run_vec[g])));
    end

endmodule

bind multi_timer_unit mtu_checker #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .PRE_W      (PRE_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pre_wr_val (pre_wr_val),
    .pre_val    (pre_val),
    .pre_rld    (pre_rld),
    .ch_hit     (ch_hit),
    .run_vec    (run_vec),
    .auto_vec   (auto_vec),
    .ie_vec     (ie_vec),
    .cnt_arr    (cnt_arr),
    .irq        (irq),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/multi_timer_unit_tb.sv
module multi_timer_unit_tb;

    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NT-1:0] irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    multi_timer_unit #(.NUM_TIMERS(NT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic logic [5:0] ta(input int ch, input int slot);
        return 6'(4 + 4 * ch + slot);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic count_irq(input int ch, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (irq[ch]) c++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq), 0);
        rd(0, d); check("R1 pre count", d, 0);
        rd(1, d); check("R1 pre reload", d, 0);
        rd(2, d); check("R1 status", d, NT);
        for (int c = 0; c < NT; c++) begin
            rd(ta(c, 0), d); check("R1 count", d, 0);
            rd(ta(c, 2), d); check("R1 ctrl", d, 0);
        end
    endtask

    task automatic t_stop_mode();
        logic [31:0] d; int c;
        wr(ta(0, 1), 5);
        wr(ta(0, 2), 32'hD);           // run, load, irq enable
        count_irq(0, 20, c);
        check("R6 R8 single pulse", c, 1);
        rd(ta(0, 0), d); check("R6 count parked", d, 0);
        rd(ta(0, 2), d); check("R6 run cleared", d, 32'h8);
    endtask

    task automatic t_auto();
        logic [31:0] d; int c;
        wr(ta(1, 1), 3);
        wr(ta(1, 2), 32'hF);
        repeat (8) @(negedge clk);
        count_irq(1, 40, c);
        check("R5 period reload+1", c, 10);
        rd(ta(1, 2), d); check("R7 load bit reads 0", d, 32'hB);
        wr(ta(1, 2), 0);
    endtask

    task automatic t_prescale();
        logic [31:0] d1, d2; int c;
        wr(1, 3);
        wr(0, 3);
        rd(1, d1); check("R3 pre reload readback", d1, 3);
        rd(0, d1); rd(0, d2);
        check("R3 pre steps", d2, (d1 == 0) ? 32'd3 : d1 - 1);
        wr(ta(2, 1), 1);
        wr(ta(2, 2), 32'hF);
        repeat (16) @(negedge clk);
        count_irq(2, 80, c);
        check("R3 tick every 4 clocks", c, 10);
        wr(ta(2, 2), 0);
        wr(1, 0);
        wr(0, 0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        wr(ta(3, 2), 0);
        wr(ta(3, 0), 7);
        repeat (20) @(negedge clk);
        rd(ta(3, 0), d); check("R4 held while stopped", d, 7);
    endtask

    task automatic t_load_bit();
        logic [31:0] d;
        wr(ta(3, 1), 2);
        wr(ta(3, 0), 9);
        wr(ta(3, 2), 0);
        rd(ta(3, 0), d); check("R7 load=0 no effect", d, 9);
        wr(ta(3, 2), 32'h4);
        rd(ta(3, 0), d); check("R7 load copies reload", d, 2);
        rd(ta(3, 2), d); check("R7 ctrl after load", d, 0);
    endtask

    task automatic t_no_irq();
        int c;
        wr(ta(0, 1), 2);
        wr(ta(0, 2), 32'h3);
        count_irq(0, 30, c);
        check("R8 no pulse when disabled", c, 0);
        wr(ta(0, 2), 0);
    endtask

    task automatic t_write_priority();
        logic [31:0] d;
        wr(ta(0, 1), 1000);
        wr(ta(0, 2), 32'h7);
        repeat (5) @(negedge clk);
        wr(ta(0, 0), 100);
        rd(ta(0, 0), d); check("R9 write wins over tick", d, 100);
        rd(ta(0, 0), d); check("R9 counting resumes", d, 99);
        wr(ta(0, 2), 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(3, 32'hFFFF);
        rd(3, d); check("R2 common spare", d, 0);
        wr(ta(0, 3), 32'hFFFF);
        rd(ta(0, 3), d); check("R2 timer spare", d, 0);
        wr(ta(NT, 1), 32'h55);
        rd(ta(NT, 1), d); check("R2 absent timer", d, 0);
        wr(ta(3, 0), 32'h12345);
        rd(ta(3, 0), d); check("R2 count width", d, 32'h2345);
    endtask

    task automatic t_indep();
        int c0, c1;
        wr(ta(0, 1), 1);
        wr(ta(1, 1), 4);
        wr(ta(0, 2), 32'hF);
        wr(ta(1, 2), 32'hF);
        repeat (10) @(negedge clk);
        c0 = 0; c1 = 0;
        repeat (60) begin
            @(negedge clk);
            if (irq[0]) c0++;
            if (irq[1]) c1++;
        end
        check("R10 timer0 period 2", c0, 30);
        check("R10 timer1 period 5", c1, 12);
        wr(ta(0, 2), 0);
        wr(ta(1, 2), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_mode();
        t_auto();
        t_prescale();
        t_hold();
        t_load_bit();
        t_no_irq();
        t_write_priority();
        t_map();
        t_indep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule